// File: doc/BRIEF.md
# Fused multiply-add special-case resolver

This block is the decision front end of a double-precision fused multiply-add that forms z + x·y, where either the product or the addend may be negated. The three operands arrive already classified, together with their signs and raw 64-bit encodings, two negate controls and the rounding mode. The block does not compute a sum. It decides whether the operation has an answer that needs no arithmetic at all. That answer may be a NaN, an infinity, a signed zero or z itself. Otherwise it tells the downstream datapath to go ahead, and hands it the effective product and addend signs.

Each operation is accepted in any cycle in which `in_valid` is high. Its verdict appears on the registered outputs one clock later. Exactly one of two things is reported: a special result with its 64-bit value and an invalid-operation flag, or a proceed indication. The four common variants differ only in the negate controls. Multiply-add negates nothing. Multiply-subtract negates the addend. Negated multiply-subtract negates the product. Negated multiply-add negates both.

Top module: `fma_sc_resolver`

## Requirements
- R1: Class codes are 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 quiet NaN and 5 signalling NaN. The effective product sign is x_sign XOR y_sign XOR neg_prod. The effective addend sign is z_sign XOR neg_add. Both appear on prod_sign and add_sign one cycle after in_valid.
- R2: If any operand is a signalling NaN, the result is the first such operand in the order z, x, y. It is returned with fraction bit 51 set, and invalid is raised.
- R3: If there is no signalling NaN but some operand is a quiet NaN, the result is the first quiet NaN in the order z, x, y. Its encoding is unchanged and invalid stays low.
- R4: If there is no NaN and one factor is infinite while the other is zero, invalid is raised and the result is the default NaN 0x7FF8000000000000.
- R5: An infinite product (no zero factor) with an infinite z of the opposite effective sign raises invalid and gives the default NaN. Any other z gives infinity with the product sign.
- R6: A finite product, zero or nonzero, with an infinite z gives infinity with the effective addend sign, and no invalid.
- R7: A zero product with a zero z gives zero carrying the common sign when the effective signs agree. When they differ it gives +0, or -0 when the rounding mode is 3 (toward negative). The other mode codes are 0 nearest, 1 toward zero and 2 toward positive.
- R8: A zero product with a subnormal or normal z gives z's magnitude bits with the effective addend sign.
- R9: Two subnormal or normal factors with a finite z raise proceed. In that case special and invalid stay low and result reads zero.
- R10: out_valid is high exactly one cycle after an in_valid cycle. While it is high, exactly one of special and proceed is high. While it is low, special, proceed and invalid are all low.
- R11: While rst_n is low, out_valid, special, invalid and proceed are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| x_cls | input | 3 | Class code of multiplicand x |
| y_cls | input | 3 | Class code of multiplier y |
| z_cls | input | 3 | Class code of addend z |
| x_sign | input | 1 | Sign of x |
| y_sign | input | 1 | Sign of y |
| z_sign | input | 1 | Sign of z |
| x_raw | input | 64 | Encoding of x |
| y_raw | input | 64 | Encoding of y |
| z_raw | input | 64 | Encoding of z |
| neg_prod | input | 1 | Negate the product |
| neg_add | input | 1 | Negate the addend |
| rmode | input | 2 | Rounding mode code |
| out_valid | output | 1 | Verdict present this cycle |
| special | output | 1 | Result is final, no arithmetic needed |
| result | output | 64 | Special result value |
| invalid | output | 1 | Invalid-operation exception |
| proceed | output | 1 | Hand the operation to the datapath |
| prod_sign | output | 1 | Effective product sign |
| add_sign | output | 1 | Effective addend sign |

## Verification
All 216 combinations of x, y and z class are driven. Each is repeated under every combination of the two negate controls, several sign patterns and both round-toward-negative and other modes. This separates rules that look alike. Quiet versus signalling NaN precedence across operand positions shows whether the design takes the right NaN. Same-sign versus opposite-sign infinite z separates the invalid case from a plain infinity. Matching versus differing zero signs under each rounding mode exposes the exact-zero sign rule. Each NaN operand carries its own payload, so a result taken from the wrong operand cannot match by chance.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } opclass_e;

  localparam logic [1:0] RM_TO_NEG = 2'd3;

  // operand slots in NaN precedence order (lowest index wins)
  localparam int SLOT_Z = 0;
  localparam int SLOT_X = 1;
  localparam int SLOT_Y = 2;
  localparam int N_OPS  = 3;

endpackage

// File: rtl/fma_sc_signs.sv
module fma_sc_signs (
  input  logic x_sign,
  input  logic y_sign,
  input  logic z_sign,
  input  logic neg_prod,
  input  logic neg_add,
  output logic prod_sign,
  output logic add_sign
);

  always_comb begin
    prod_sign = (x_sign ^ y_sign) ^ neg_prod;
    add_sign  = z_sign ^ neg_add;
  end

endmodule

// File: rtl/fma_sc_nan_pick.sv
module fma_sc_nan_pick
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [N_OPS*3-1:0] cls_pk,
  input  logic [N_OPS*W-1:0] raw_pk,
  output logic               nan_hit,
  output logic               nan_inv,
  output logic [W-1:0]       nan_val
);

  localparam int QBIT = FRAC_W - 1;

  logic [N_OPS-1:0] is_sn;
  logic [N_OPS-1:0] is_qn;
  logic [W-1:0]     quieted [N_OPS];
  logic [W-1:0]     as_is   [N_OPS];

  genvar g;
  generate
    for (g = 0; g < N_OPS; g++) begin : g_op
      opclass_e c;
      assign c          = opclass_e'(cls_pk[g*3 +: 3]);
      assign is_sn[g]   = (c == CLS_SNAN);
      assign is_qn[g]   = (c == CLS_QNAN);
      assign as_is[g]   = raw_pk[g*W +: W];
      assign quieted[g] = raw_pk[g*W +: W] | (W'(1) << QBIT);
    end
  endgenerate

  // later iterations overwrite earlier ones: walk from lowest priority up
  always_comb begin
    nan_hit = 1'b0;
    nan_inv = 1'b0;
    nan_val = '0;
    for (int i = N_OPS - 1; i >= 0; i--) begin
      if (is_qn[i]) begin
        nan_hit = 1'b1;
        nan_val = as_is[i];
      end
    end
    for (int i = N_OPS - 1; i >= 0; i--) begin
      if (is_sn[i]) begin
        nan_hit = 1'b1;
        nan_inv = 1'b1;
        nan_val = quieted[i];
      end
    end
  end

endmodule

// File: rtl/fma_sc_arith.sv
module fma_sc_arith
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  opclass_e     x_cls,
  input  opclass_e     y_cls,
  input  opclass_e     z_cls,
  input  logic         prod_sign,
  input  logic         add_sign,
  input  logic [W-1:0] z_raw,
  input  logic [1:0]   rmode,
  output logic         ar_hit,
  output logic         ar_inv,
  output logic         ar_go,
  output logic [W-1:0] ar_val
);

  localparam logic [W-2:0] MAG_INF  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [W-1:0] DFLT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic x_inf, y_inf, x_zero, y_zero, z_inf, z_zero;
  logic inf_times_zero, prod_inf, prod_zero;

  always_comb begin
    x_inf  = (x_cls == CLS_INF);
    y_inf  = (y_cls == CLS_INF);
    z_inf  = (z_cls == CLS_INF);
    x_zero = (x_cls == CLS_ZERO);
    y_zero = (y_cls == CLS_ZERO);
    z_zero = (z_cls == CLS_ZERO);
    inf_times_zero = (x_inf && y_zero) || (x_zero && y_inf);
    prod_inf  = x_inf || y_inf;
    prod_zero = x_zero || y_zero;
  end

  always_comb begin
    ar_hit = 1'b1;
    ar_inv = 1'b0;
    ar_go  = 1'b0;
    ar_val = '0;
    if (inf_times_zero) begin
      ar_inv = 1'b1;
      ar_val = DFLT_NAN;
    end else if (prod_inf) begin
      if (z_inf && (add_sign != prod_sign)) begin
        ar_inv = 1'b1;
        ar_val = DFLT_NAN;
      end else begin
        ar_val = {prod_sign, MAG_INF};
      end
    end else if (z_inf) begin
      ar_val = {add_sign, MAG_INF};
    end else if (prod_zero) begin
      if (z_zero) begin
        if (add_sign == prod_sign) ar_val = {add_sign, {(W-1){1'b0}}};
        else                       ar_val = {(rmode == RM_TO_NEG), {(W-1){1'b0}}};
      end else begin
        ar_val = {add_sign, z_raw[W-2:0]};
      end
    end else begin
      ar_hit = 1'b0;
      ar_go  = 1'b1;
    end
  end

endmodule

// File: rtl/fma_sc_resolver.sv
module fma_sc_resolver
  import fma_sc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   x_cls,
  input  logic [2:0]   y_cls,
  input  logic [2:0]   z_cls,
  input  logic         x_sign,
  input  logic         y_sign,
  input  logic         z_sign,
  input  logic [W-1:0] x_raw,
  input  logic [W-1:0] y_raw,
  input  logic [W-1:0] z_raw,
  input  logic         neg_prod,
  input  logic         neg_add,
  input  logic [1:0]   rmode,
  output logic         out_valid,
  output logic         special,
  output logic [W-1:0] result,
  output logic         invalid,
  output logic         proceed,
  output logic         prod_sign,
  output logic         add_sign
);

  logic         eff_ps, eff_as;
  logic         nan_hit, nan_inv;
  logic [W-1:0] nan_val;
  logic         ar_hit, ar_inv, ar_go;
  logic [W-1:0] ar_val;

  logic         vld_d, spc_d, inv_d, go_d;
  logic [W-1:0] res_d;
  logic         vld_q, spc_q, inv_q, go_q, ps_q, as_q;
  logic [W-1:0] res_q;

  fma_sc_signs u_signs (
    .x_sign    (x_sign),
    .y_sign    (y_sign),
    .z_sign    (z_sign),
    .neg_prod  (neg_prod),
    .neg_add   (neg_add),
    .prod_sign (eff_ps),
    .add_sign  (eff_as)
  );

  fma_sc_nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
    .cls_pk  ({y_cls, x_cls, z_cls}),
    .raw_pk  ({y_raw, x_raw, z_raw}),
    .nan_hit (nan_hit),
    .nan_inv (nan_inv),
    .nan_val (nan_val)
  );

  fma_sc_arith #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_arith (
    .x_cls     (opclass_e'(x_cls)),
    .y_cls     (opclass_e'(y_cls)),
    .z_cls     (opclass_e'(z_cls)),
    .prod_sign (eff_ps),
    .add_sign  (eff_as),
    .z_raw     (z_raw),
    .rmode     (rmode),
    .ar_hit    (ar_hit),
    .ar_inv    (ar_inv),
    .ar_go     (ar_go),
    .ar_val    (ar_val)
  );

  // next state
  always_comb begin
    vld_d = in_valid;
    spc_d = 1'b0;
    inv_d = 1'b0;
    go_d  = 1'b0;
    res_d = res_q;
    if (in_valid) begin
      if (nan_hit) begin
        spc_d = 1'b1;
        inv_d = nan_inv;
        res_d = nan_val;
      end else begin
        spc_d = ar_hit;
        inv_d = ar_inv;
        go_d  = ar_go;
        res_d = ar_val;
      end
    end
  end

  // control flags: always updated, cleared on idle cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      spc_q <= 1'b0;
      inv_q <= 1'b0;
      go_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      spc_q <= spc_d;
      inv_q <= inv_d;
      go_q  <= go_d;
    end
  end

  // data: enabled by in_valid only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ps_q  <= 1'b0;
      as_q  <= 1'b0;
    end else if (in_valid) begin
      res_q <= res_d;
      ps_q  <= eff_ps;
      as_q  <= eff_as;
    end
  end

  assign out_valid = vld_q;
  assign special   = spc_q;
  assign result    = res_q;
  assign invalid   = inv_q;
  assign proceed   = go_q;
  assign prod_sign = ps_q;
  assign add_sign  = as_q;

endmodule

// File: rtl/fma_sc_chk.sv
module fma_sc_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         x_sign,
  input logic         y_sign,
  input logic         z_sign,
  input logic         neg_prod,
  input logic         neg_add,
  input logic         out_valid,
  input logic         special,
  input logic [W-1:0] result,
  input logic         invalid,
  input logic         proceed,
  input logic         prod_sign,
  input logic         add_sign
);

  localparam int QBIT = FRAC_W - 1;

  logic exp_ones;
  assign exp_ones = &result[W-2:FRAC_W];

  a_r1_prod_sign: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> prod_sign == $past(x_sign ^ y_sign ^ neg_prod));

  a_r1_add_sign: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> add_sign == $past(z_sign ^ neg_add));

  a_r10_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (special ^ proceed));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !special && !proceed && !invalid);

  a_r9_proceed_clean: assert property (@(posedge clk) disable iff (!rst_n)
    proceed |-> !invalid && result == '0);

  a_r2_nan_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (special && exp_ones && (|result[FRAC_W-1:0])) |-> result[QBIT]);

  a_r4_invalid_gives_nan: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> special && exp_ones && result[QBIT]);

endmodule

bind fma_sc_resolver fma_sc_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .x_sign    (x_sign),
  .y_sign    (y_sign),
  .z_sign    (z_sign),
  .neg_prod  (neg_prod),
  .neg_add   (neg_add),
  .out_valid (out_valid),
  .special   (special),
  .result    (result),
  .invalid   (invalid),
  .proceed   (proceed),
  .prod_sign (prod_sign),
  .add_sign  (add_sign)
);

// File: tb/test_fma_sc_resolver.sv
module test_fma_sc_resolver;

  typedef struct {
    logic        spc;
    logic [63:0] val;
    logic        inv;
    logic        go;
    logic        ps;
    logic        as_;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  x_cls, y_cls, z_cls;
  logic        x_sign, y_sign, z_sign;
  logic [63:0] x_raw, y_raw, z_raw;
  logic        neg_prod, neg_add;
  logic [1:0]  rmode;
  logic        out_valid, special, invalid, proceed, prod_sign, add_sign;
  logic [63:0] result;

  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  fma_sc_resolver i_fma_sc_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x_cls(x_cls), .y_cls(y_cls), .z_cls(z_cls),
    .x_sign(x_sign), .y_sign(y_sign), .z_sign(z_sign),
    .x_raw(x_raw), .y_raw(y_raw), .z_raw(z_raw),
    .neg_prod(neg_prod), .neg_add(neg_add), .rmode(rmode),
    .out_valid(out_valid), .special(special), .result(result),
    .invalid(invalid), .proceed(proceed),
    .prod_sign(prod_sign), .add_sign(add_sign)
  );

  localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;

  // encoding for a class; tag gives each operand its own payload
  function automatic logic [63:0] enc(input logic [2:0] c, input logic s, input logic [7:0] tag);
    case (c)
      3'd0:    return {s, 63'd0};
      3'd1:    return {s, 11'd0, 32'd0, 12'h0, tag};
      3'd2:    return {s, 11'h3FF, 20'd0, 24'h0, tag};
      3'd3:    return {s, 11'h7FF, 52'd0};
      3'd4:    return {s, 11'h7FF, 1'b1, 43'd0, tag};
      default: return {s, 11'h7FF, 1'b0, 43'd0, tag};
    endcase
  endfunction

  function automatic exp_t predict(input logic [2:0] xc, yc, zc,
                                   input logic sx, sy, sz, np, na,
                                   input logic [1:0] rm,
                                   input logic [63:0] xr, yr, zr);
    exp_t e;
    logic ps, as_;
    ps = sx ^ sy ^ np;
    as_ = sz ^ na;
    e.ps = ps; e.as_ = as_;
    e.spc = 1'b1; e.inv = 1'b0; e.go = 1'b0; e.val = 64'd0;
    if (zc == 5 || xc == 5 || yc == 5) begin
      e.tag = "R2"; e.inv = 1'b1;
      e.val = (zc == 5) ? zr : (xc == 5) ? xr : yr;
      e.val[51] = 1'b1;
    end else if (zc == 4 || xc == 4 || yc == 4) begin
      e.tag = "R3";
      e.val = (zc == 4) ? zr : (xc == 4) ? xr : yr;
    end else if ((xc == 3 && yc == 0) || (xc == 0 && yc == 3)) begin
      e.tag = "R4"; e.inv = 1'b1; e.val = DNAN;
    end else if (xc == 3 || yc == 3) begin
      e.tag = "R5";
      if (zc == 3 && ps != as_) begin e.inv = 1'b1; e.val = DNAN; end
      else e.val = {ps, 11'h7FF, 52'd0};
    end else if (zc == 3) begin
      e.tag = "R6"; e.val = {as_, 11'h7FF, 52'd0};
    end else if (xc == 0 || yc == 0) begin
      if (zc == 0) begin
        e.tag = "R7";
        e.val = (ps == as_) ? {as_, 63'd0} : {rm == 2'd3, 63'd0};
      end else begin
        e.tag = "R8"; e.val = {as_, zr[62:0]};
      end
    end else begin
      e.tag = "R9"; e.spc = 1'b0; e.go = 1'b1;
    end
    return e;
  endfunction

  task automatic drive(input logic [2:0] xc, yc, zc,
                       input logic sx, sy, sz, np, na, input logic [1:0] rm);
    @(negedge clk);
    x_cls = xc; y_cls = yc; z_cls = zc;
    x_sign = sx; y_sign = sy; z_sign = sz;
    x_raw = enc(xc, sx, 8'h11); y_raw = enc(yc, sy, 8'h22); z_raw = enc(zc, sz, 8'h33);
    neg_prod = np; neg_add = na; rmode = rm;
    in_valid = 1'b1;
    sb.push_back(predict(xc, yc, zc, sx, sy, sz, np, na, rm, x_raw, y_raw, z_raw));
  endtask

  // monitor / scoreboard compare
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected out_valid act=1 exp=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (special !== e.spc || result !== e.val || invalid !== e.inv ||
              proceed !== e.go || prod_sign !== e.ps || add_sign !== e.as_) begin
            errors++;
            $display("FAIL %s act spc=%b val=%h inv=%b go=%b ps=%b as=%b exp spc=%b val=%h inv=%b go=%b ps=%b as=%b (R1 signs)",
                     e.tag, special, result, invalid, proceed, prod_sign, add_sign,
                     e.spc, e.val, e.inv, e.go, e.ps, e.as_);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1;
    x_cls = 0; y_cls = 0; z_cls = 0; x_sign = 0; y_sign = 0; z_sign = 0;
    x_raw = 0; y_raw = 0; z_raw = 0; neg_prod = 0; neg_add = 0; rmode = 0;
    repeat (3) @(negedge clk);
    // R11: reset state even with in_valid asserted
    checks++;
    if (out_valid !== 1'b0 || special !== 1'b0 || invalid !== 1'b0 || proceed !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset act=%b%b%b%b exp=0000", out_valid, special, invalid, proceed);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: R5 infinite product versus infinite z of opposite sign
    drive(3'd3, 3'd2, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
    // R5 same sign: infinity result
    drive(3'd3, 3'd3, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
    // R7 differing zeros, round toward negative, then nearest
    drive(3'd0, 3'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3);
    drive(3'd0, 3'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0);
    // R2 vs R3: quiet z loses to signalling y
    drive(3'd2, 3'd5, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);

    // exhaustive class triples with varied signs, negations, modes
    for (int c = 0; c < 216; c++) begin
      for (int v = 0; v < 8; v++) begin
        drive(3'(c % 6), 3'((c / 6) % 6), 3'(c / 36),
              v[0] ^ v[2], v[1], v[2], v[0], v[1],
              v[2] ? 2'd3 : 2'(c % 3));
      end
      if (c % 17 == 0) begin
        @(negedge clk); in_valid = 1'b0;   // idle gaps between bursts
      end
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);

    // R10: idle output and drained scoreboard
    checks++;
    if (out_valid !== 1'b0 || sb.size() != 0) begin
      errors++;
      $display("FAIL R10 idle act=%b/%0d exp=0/0", out_valid, sb.size());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule